// File: doc/BRIEF.md
# Counter Overflow Request Router

The router takes overflow pulses from three event counters and one cycle counter and turns them into four request lines: a normal interrupt, a fast interrupt, a reset request and a debug request. Each overflow pulse sets a sticky status bit. Each request line has its own enable mask. A request line is active while any source that is both enabled in its mask and flagged in the status vector is present.

Software changes the masks through a small coprocessor-style port. A 3-bit select picks one of eight views. Each request type has a set view and a clear view, so enabling and disabling never need a read-modify-write. Access is allowed in privileged mode, and in user mode only while the user-enable input is high. The counters, the interrupt and reset controllers and the debugger are all outside the block.

Top module: `ovf_req_router`

## Requirements
- R1: After reset all four masks and all status bits are zero, irq_no, fiq_no and rst_req_no are high, and dbg_req_o is low.
- R2: Select values 0, 1, 2 and 3 are the set views for the normal interrupt, fast interrupt, reset and debug masks. A permitted write to a set view enables every source whose data bit is 1 and leaves the others unchanged.
- R3: Select values 4 to 7 are the clear views of the same four masks, in the same order. A permitted write to a clear view disables every source whose data bit is 1 and leaves the others unchanged.
- R4: A permitted read of either view of a request type returns that type's current mask in the same cycle. Bit 31 is the cycle counter and bits 2, 1 and 0 are event counters 2, 1 and 0. A read that is not permitted, and any cycle with no read, returns zero.
- R5: Bits 30 to 3 always read as zero, and the values written to them have no effect.
- R6: irq_no, fiq_no and rst_req_no are driven low, and dbg_req_o is driven high, when some source is enabled in that output's mask and has its status bit set. Every output is a register that takes its new value on the clock edge that captures the mask write or the overflow pulse.
- R7: Each overflow pulse sets a status bit that stays set until stat_clr_i is pulsed with that bit. In stat_clr_i, bit 3 is the cycle counter and bits 2 to 0 are event counters 2 to 0. If a bit is set and cleared in the same cycle, the set wins.
- R8: An access is permitted when priv_i is high, or when user_en_i is high. A denied access changes no mask and reads zero. It drives acc_err_o high for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 3 | View select: bit 2 chooses clear (1) or set (0), bits 1:0 choose the request type |
| acc_wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access is made in privileged mode |
| user_en_i | input | 1 | Allows access in user mode |
| acc_rdata_o | output | 32 | Read data, combinational |
| acc_err_o | output | 1 | One-cycle pulse after a denied access |
| evt_ovf_i | input | 3 | Overflow pulses from event counters 2..0 |
| cyc_ovf_i | input | 1 | Overflow pulse from the cycle counter |
| stat_clr_i | input | 4 | Status clear pulses: bit 3 is the cycle counter, bits 2..0 are the event counters |
| irq_no | output | 1 | Normal interrupt request, active low |
| fiq_no | output | 1 | Fast interrupt request, active low |
| rst_req_no | output | 1 | Reset request, active low |
| dbg_req_o | output | 1 | Debug request, active high |

## Verification
A wrong mask bit is visible at once on a read of either view of that type. It also shows on the matching request pin one cycle after any overflow of the affected source. A lost or spurious status bit makes a request pin go active or stay inactive against the expected pattern on the edge after the pulse. That wrong level stays until the next status clear, so a sticky error cannot hide between samples. A wrong grant decision shows in the same cycle as a non-zero denied read, and one cycle later on acc_err_o. A mask that a denied write altered shows on the next permitted read.

// File: rtl/ovf_req_pkg.sv
package ovf_req_pkg;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned NUM_EVT = 3;
  parameter int unsigned NUM_REQ = 4;
  parameter int unsigned SEL_W   = 3;
  localparam int unsigned SRC_W  = NUM_EVT + 1;
  localparam int unsigned CYC_BIT = DATA_W - 1;
  typedef enum logic [1:0] {
    REQ_IRQ = 2'd0,
    REQ_FIQ = 2'd1,
    REQ_RST = 2'd2,
    REQ_DBG = 2'd3
  } req_kind_e;
endpackage

// File: rtl/ovf_req_status.sv
module ovf_req_status #(
  parameter int unsigned SRC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] stat_d_o,
  output logic [SRC_W-1:0] stat_q_o
);
  // a new overflow beats a clear in the same cycle
  always_comb stat_d_o = (stat_q_o & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q_o <= '0;
    else         stat_q_o <= stat_d_o;
  end
endmodule

// File: rtl/ovf_req_mask_bank.sv
module ovf_req_mask_bank #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned SRC_W  = NUM_EVT + 1,
  localparam int unsigned CYC_BIT = DATA_W - 1,
  localparam int unsigned KIND_W = SEL_W - 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            acc_en_i,
  input  logic                            acc_wr_i,
  input  logic [SEL_W-1:0]                acc_sel_i,
  input  logic [DATA_W-1:0]               acc_wdata_i,
  input  logic                            priv_i,
  input  logic                            user_en_i,
  output logic [DATA_W-1:0]               acc_rdata_o,
  output logic                            acc_err_o,
  output logic [NUM_REQ-1:0][SRC_W-1:0]   mask_d_o
);
  logic [NUM_REQ-1:0][SRC_W-1:0] mask_q;
  logic                          grant, wr_ok, rd_ok, clr_view;
  logic [KIND_W-1:0]             kind;
  logic [SRC_W-1:0]              wbits, rd_mask;
  logic                          rsvd_unused;

  assign grant    = priv_i | user_en_i;
  assign wr_ok    = acc_en_i & acc_wr_i & grant;
  assign rd_ok    = acc_en_i & ~acc_wr_i & grant;
  assign kind     = acc_sel_i[KIND_W-1:0];
  assign clr_view = acc_sel_i[SEL_W-1];
  assign wbits    = {acc_wdata_i[CYC_BIT], acc_wdata_i[NUM_EVT-1:0]};
  assign rsvd_unused = ^acc_wdata_i[CYC_BIT-1:NUM_EVT];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_mask
    always_comb begin
      mask_d_o[g] = mask_q[g];
      if (wr_ok && kind == KIND_W'(g))
        mask_d_o[g] = clr_view ? (mask_q[g] & ~wbits) : (mask_q[g] | wbits);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      acc_err_o <= 1'b0;
    end else begin
      mask_q    <= mask_d_o;
      acc_err_o <= acc_en_i & ~grant;
    end
  end

  assign rd_mask = mask_q[kind];
  always_comb begin
    acc_rdata_o = '0;
    if (rd_ok) begin
      acc_rdata_o[NUM_EVT-1:0] = rd_mask[NUM_EVT-1:0];
      acc_rdata_o[CYC_BIT]     = rd_mask[NUM_EVT];
    end
  end
endmodule

// File: rtl/ovf_req_drive.sv
module ovf_req_drive #(
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned NUM_REQ = 4,
  parameter logic [NUM_REQ-1:0] ACT_LOW = '1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REQ-1:0][SRC_W-1:0] mask_i,
  input  logic [SRC_W-1:0]              stat_i,
  output logic [NUM_REQ-1:0]            req_o
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic hit;
    assign hit = |(mask_i[g] & stat_i);
    if (ACT_LOW[g]) begin : g_low
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_o[g] <= 1'b1;
        else         req_o[g] <= ~hit;
      end
    end else begin : g_high
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_o[g] <= 1'b0;
        else         req_o[g] <= hit;
      end
    end
  end
endmodule

// File: rtl/ovf_req_router.sv
module ovf_req_router
  import ovf_req_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_en_i,
  input  logic                acc_wr_i,
  input  logic [SEL_W-1:0]    acc_sel_i,
  input  logic [DATA_W-1:0]   acc_wdata_i,
  input  logic                priv_i,
  input  logic                user_en_i,
  output logic [DATA_W-1:0]   acc_rdata_o,
  output logic                acc_err_o,
  input  logic [NUM_EVT-1:0]  evt_ovf_i,
  input  logic                cyc_ovf_i,
  input  logic [SRC_W-1:0]    stat_clr_i,
  output logic                irq_no,
  output logic                fiq_no,
  output logic                rst_req_no,
  output logic                dbg_req_o
);
  localparam logic [NUM_REQ-1:0] REQ_ACT_LOW = 4'b0111;

  logic [NUM_REQ-1:0][SRC_W-1:0] mask_d;
  logic [SRC_W-1:0]              stat_d, stat_q;
  logic [NUM_REQ-1:0]            req;

  ovf_req_mask_bank #(
    .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .NUM_REQ(NUM_REQ), .SEL_W(SEL_W)
  ) u_bank (
    .clk_i, .rst_ni, .acc_en_i, .acc_wr_i, .acc_sel_i, .acc_wdata_i,
    .priv_i, .user_en_i, .acc_rdata_o, .acc_err_o, .mask_d_o(mask_d)
  );

  ovf_req_status #(.SRC_W(SRC_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i   ({cyc_ovf_i, evt_ovf_i}),
    .clr_i   (stat_clr_i),
    .stat_d_o(stat_d),
    .stat_q_o(stat_q)
  );

  ovf_req_drive #(.SRC_W(SRC_W), .NUM_REQ(NUM_REQ), .ACT_LOW(REQ_ACT_LOW)) u_drv (
    .clk_i, .rst_ni, .mask_i(mask_d), .stat_i(stat_d), .req_o(req)
  );

  assign irq_no     = req[REQ_IRQ];
  assign fiq_no     = req[REQ_FIQ];
  assign rst_req_no = req[REQ_RST];
  assign dbg_req_o  = req[REQ_DBG];
endmodule

// File: rtl/ovf_req_router_chk.sv
module ovf_req_router_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned NUM_REQ = 4,
  parameter logic [NUM_REQ-1:0] ACT_LOW = 4'b0111,
  localparam int unsigned SRC_W  = NUM_EVT + 1,
  localparam int unsigned CYC_BIT = DATA_W - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_en_i,
  input logic               acc_wr_i,
  input logic               priv_i,
  input logic               user_en_i,
  input logic [DATA_W-1:0]  acc_rdata_o,
  input logic               acc_err_o,
  input logic [SRC_W-1:0]   ovf_i,
  input logic [SRC_W-1:0]   clr_i,
  input logic [SRC_W-1:0]   stat_i,
  input logic [NUM_REQ-1:0] req_i
);
  logic denied;
  assign denied = acc_en_i & ~priv_i & ~user_en_i;

  AST_DENIED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied |=> acc_err_o); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> $past(denied)); // R8
  AST_DENIED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (denied && !acc_wr_i) |-> (acc_rdata_o == '0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdata_o[CYC_BIT-1:NUM_EVT] == '0); // R5
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & ~clr_i) != '0) |=> ((stat_i & $past(stat_i & ~clr_i)) == $past(stat_i & ~clr_i))); // R7
  AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i != '0) |=> ((stat_i & $past(ovf_i)) == $past(ovf_i))); // R7
  AST_REQ_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i ^ ACT_LOW) != '0) |-> (stat_i != '0)); // R6
endmodule

bind ovf_req_router ovf_req_router_chk #(
  .DATA_W(ovf_req_pkg::DATA_W), .NUM_EVT(ovf_req_pkg::NUM_EVT),
  .NUM_REQ(ovf_req_pkg::NUM_REQ), .ACT_LOW(4'b0111)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i),
  .priv_i(priv_i), .user_en_i(user_en_i), .acc_rdata_o(acc_rdata_o),
  .acc_err_o(acc_err_o), .ovf_i({cyc_ovf_i, evt_ovf_i}), .clr_i(stat_clr_i),
  .stat_i(stat_q), .req_i({dbg_req_o, rst_req_no, fiq_no, irq_no})
);

// File: tb/ovf_req_router_tb_top.sv
module ovf_req_router_tb_top;
  localparam logic [31:0] LEGAL = 32'h8000_0007;

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 request pins, 2 access error
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, priv = 1'b0, uen = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [2:0]  evt_ovf = '0;
  logic        cyc_ovf = 1'b0;
  logic [3:0]  sclr = '0;
  logic        irq_n, fiq_n, rst_req_n, dbg_req;

  int cyc = 0, total = 0, fails = 0;
  bit done = 1'b0;
  item_t q[$];
  logic [31:0] m [4];
  logic [3:0]  st;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ovf_req_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
    .acc_sel_i(sel), .acc_wdata_i(wdata), .priv_i(priv), .user_en_i(uen),
    .acc_rdata_o(rdata), .acc_err_o(err), .evt_ovf_i(evt_ovf),
    .cyc_ovf_i(cyc_ovf), .stat_clr_i(sclr), .irq_no(irq_n), .fiq_no(fiq_n),
    .rst_req_no(rst_req_n), .dbg_req_o(dbg_req)
  );

  function automatic logic [3:0] exp_pins();
    logic [31:0] s32;
    logic [3:0]  h;
    s32 = {st[3], 28'd0, st[2:0]};
    for (int t = 0; t < 4; t++) h[t] = |(m[t] & s32);
    return {~h[0], ~h[1], ~h[2], h[3]};  // {irq_n, fiq_n, rst_req_n, dbg_req}
  endfunction

  // driver: one cycle of stimulus, expected results pushed in due order
  task automatic drv(input logic en, input logic wr, input logic [2:0] s,
                     input logic [31:0] wd, input logic pv, input logic ue,
                     input logic [3:0] ovf, input logic [3:0] clr, input string tag);
    item_t it;
    logic  g;
    @(negedge clk);
    acc_en = en; acc_wr = wr; sel = s; wdata = wd; priv = pv; uen = ue;
    evt_ovf = ovf[2:0]; cyc_ovf = ovf[3]; sclr = clr;
    g = pv | ue;
    if (en && !wr) begin
      it.due = cyc; it.kind = 0; it.exp = g ? m[s[1:0]] : 32'h0; it.tag = tag;
      q.push_back(it);
    end
    if (en && wr && g)
      m[s[1:0]] = s[2] ? (m[s[1:0]] & ~wd) : (m[s[1:0]] | (wd & LEGAL));
    st = (st & ~clr) | ovf;
    it.due = cyc + 1; it.kind = 1; it.exp = {28'd0, exp_pins()}; it.tag = tag;
    q.push_back(it);
    it.due = cyc + 1; it.kind = 2; it.exp = {31'd0, en & ~g}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] wd, input logic pv,
                        input logic ue, input string tag);
    drv(1'b1, 1'b1, s, wd, pv, ue, 4'h0, 4'h0, tag);
  endtask
  task automatic rd_reg(input logic [2:0] s, input logic pv, input logic ue, input string tag);
    drv(1'b1, 1'b0, s, 32'h0, pv, ue, 4'h0, 4'h0, tag);
  endtask
  task automatic evt(input logic [3:0] ovf, input logic [3:0] clr, input string tag);
    drv(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0, ovf, clr, tag);
  endtask

  // monitor: compares results against the scoreboard
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        it = q.pop_front();
        case (it.kind)
          0:       act = rdata;
          1:       act = {28'd0, irq_n, fiq_n, rst_req_n, dbg_req};
          default: act = {31'd0, err};
        endcase
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 4; t++) m[t] = '0;
    st = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state on pins and in every mask
    evt(4'h0, 4'h0, "R1 reset pins");
    for (int t = 0; t < 4; t++) rd_reg(3'(t), 1'b1, 1'b0, "R1 reset mask");
    // R2/R5: set all bits, reserved bits dropped
    wr_reg(3'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R2 set irq");
    rd_reg(3'd0, 1'b1, 1'b0, "R5 reserved read zero");
    rd_reg(3'd4, 1'b1, 1'b0, "R4 clear view reads mask");
    wr_reg(3'd1, 32'h0000_0002, 1'b1, 1'b0, "R2 set fiq");
    wr_reg(3'd2, 32'h8000_0000, 1'b1, 1'b0, "R2 set rst");
    wr_reg(3'd3, 32'h0000_0001, 1'b1, 1'b0, "R2 set dbg");
    wr_reg(3'd0, 32'h0000_0000, 1'b1, 1'b0, "R2 zero bits no change");
    for (int t = 0; t < 8; t++) rd_reg(3'(t), 1'b1, 1'b0, "R4 readback");
    // R6/R7: overflow of event counter 1 drives irq and fiq
    evt(4'b0010, 4'h0, "R6 evt1 overflow");
    evt(4'h0, 4'h0, "R7 status held");
    evt(4'h0, 4'b0010, "R7 status cleared");
    evt(4'b1000, 4'h0, "R6 cycle overflow");
    // R3: clear views
    wr_reg(3'd6, 32'h8000_0000, 1'b1, 1'b0, "R3 clear rst");
    rd_reg(3'd2, 1'b1, 1'b0, "R3 rst mask cleared");
    wr_reg(3'd4, 32'h7FFF_FFF9, 1'b1, 1'b0, "R3 clear irq partial");
    rd_reg(3'd0, 1'b1, 1'b0, "R3 irq mask after clear");
    // R8: denied and overridden user access
    wr_reg(3'd4, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 denied write");
    rd_reg(3'd0, 1'b0, 1'b0, "R8 denied read");
    rd_reg(3'd0, 1'b1, 1'b0, "R8 mask unchanged");
    wr_reg(3'd3, 32'h8000_0000, 1'b0, 1'b1, "R8 user write enabled");
    rd_reg(3'd3, 1'b0, 1'b1, "R8 user read enabled");
    // R7: set beats clear in the same cycle
    evt(4'b0001, 4'b1001, "R7 set wins over clear");
    evt(4'h0, 4'h0, "R7 event0 held");
    evt(4'h0, 4'b1111, "R7 clear all");
    // R6: every source into every output
    wr_reg(3'd1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R2 fiq all");
    wr_reg(3'd2, 32'hFFFF_FFFF, 1'b1, 1'b0, "R2 rst all");
    for (int b = 0; b < 4; b++) begin
      evt(4'(1 << b), 4'h0, "R6 single source");
      evt(4'h0, 4'hF, "R7 clear source");
    end
    evt(4'h0, 4'h0, "R1 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule